// File: doc/BRIEF.md
# Protocol timeout timer with retry counter

This block times protocol events for a serial link controller. Software loads a period value, a 3-bit counter field, a mode bit and a tick-source select. A start strobe arms the timer. The timer then counts single-cycle tick pulses down from the period value until the count reaches zero. That event is an expiry.

What follows an expiry depends on the mode bit. In autonomous mode, the timer supervises an unacknowledged data frame. Each expiry asks the transmitter for one supervisory frame with the poll bit set, and the timer then rearms itself. It stops when an acknowledgement arrives. When the retries run out, it stops and raises a final interrupt. In CPU mode, every expiry raises an interrupt, and the timer rearms a bounded number of times. An all-ones counter field removes the bound in both modes: in autonomous mode polling never stops on its own, and in CPU mode an interrupt repeats every period until a reset command.

Top module: `proto_tmo_timer`

## Requirements
- R1: After asynchronous reset, poll_req_o and irq_o are low and the timer is idle.
- R2: start_i arms the timer and loads the period. reset_i stops the timer at any time and wins over a start_i in the same cycle. A reset_i cycle produces no output pulse.
- R3: An armed timer expires on the period_i-th selected tick after it is loaded. A period of 0 expires on the first tick. Every rearm reloads period_i.
- R4: In autonomous mode (auto_mode_i=1), an expiry with retries left gives a one-cycle poll_req_o pulse and no irq, and the timer rearms. A counter field N from 0 to 6 allows exactly N such polls.
- R5: In autonomous mode, a counter field of 7 (all ones) requests a poll on every expiry with no limit, and never raises irq_o by itself.
- R6: In autonomous mode, an expiry with no retries left stops the timer and gives one irq_o pulse with no poll.
- R7: In autonomous mode, ack_i on an armed timer stops it and clears the retry count. ack_i outranks a start or an expiry in the same cycle. ack_i has no effect in CPU mode.
- R8: In CPU mode (auto_mode_i=0), every expiry gives one irq_o pulse. A counter field N from 0 to 6 gives N automatic restarts, so N+1 interrupts, and then the timer stops.
- R9: In CPU mode, a counter field of 7 gives an irq_o pulse every period until reset_i.
- R10: src_sel_i=0 counts txclk_tick_i pulses. src_sel_i=1 counts fsync_tick_i pulses. The other tick input is ignored.
- R11: Ticks have no effect on an idle timer. A start_i on an armed timer restarts the full period and clears the retry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | PERIOD_W | Time-out period in ticks |
| count_i | input | CNT_W | Retry or restart limit; all ones means unlimited |
| auto_mode_i | input | 1 | 1: autonomous poll retry, 0: CPU controlled |
| src_sel_i | input | 1 | Tick source: 0 transmit clock tick, 1 frame-sync tick |
| start_i | input | 1 | Start command strobe |
| reset_i | input | 1 | Stop command strobe |
| txclk_tick_i | input | 1 | Transmit clock enable pulse |
| fsync_tick_i | input | 1 | Frame-sync enable pulse |
| ack_i | input | 1 | Acknowledge received |
| poll_req_o | output | 1 | One-cycle request for a poll supervisory frame |
| irq_o | output | 1 | One-cycle timer interrupt pulse |

## Verification
The bench builds the block with PERIOD_W reduced to 8 and the default CNT_W of 3. The narrower period lets a run at the all-ones period complete in a few hundred cycles. The 3-bit counter field keeps every limit reachable, including the all-ones unlimited value and the full set of six retries. Short periods of 0 to 4 let all retries, exhaustion and the unlimited modes cycle many times inside the random phase. These are also the conditions in which an expiry can coincide with acknowledge, start or reset strobes.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  typedef struct packed {
    logic load;
    logic stop;
    logic clr;
    logic inc;
    logic irq;
    logic poll;
  } tmo_act_t;
endpackage

// File: rtl/tmo_tick_sel.sv
module tmo_tick_sel (
  input  logic src_sel_i,
  input  logic active_i,
  input  logic txclk_tick_i,
  input  logic fsync_tick_i,
  output logic tick_o
);
  logic raw;
  assign raw    = src_sel_i ? fsync_tick_i : txclk_tick_i;
  assign tick_o = raw & active_i;
endmodule

// File: rtl/tmo_down_cnt.sv
module tmo_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  input  logic         dec_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  // zero or one remaining: this tick ends the period (period 0 acts as 1)
  assign last     = (cnt_q <= W'(1));
  assign expire_o = dec_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= value_i;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/tmo_retry_ctrl.sv
module tmo_retry_ctrl
  import tmo_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             auto_mode_i,
  input  logic             start_i,
  input  logic             reset_i,
  input  logic             ack_i,
  input  logic             expire_i,
  output logic             active_o,
  output tmo_act_t         act_o
);
  localparam logic [CNT_W-1:0] UNLIM = '1;

  logic             active_q;
  logic [CNT_W-1:0] ret_q;
  logic             unlimited;
  logic             may_retry;
  tmo_act_t         a;

  assign unlimited = (count_i == UNLIM);
  assign may_retry = unlimited | (ret_q < count_i);

  always_comb begin
    a = '0;
    if (reset_i) begin
      a.stop = 1'b1;
    end else if (auto_mode_i && ack_i && active_q) begin
      a.stop = 1'b1;
      a.clr  = 1'b1;
    end else if (start_i) begin
      a.load = 1'b1;
      a.clr  = 1'b1;
    end else if (expire_i) begin
      if (may_retry) begin
        a.load = 1'b1;
        a.inc  = ~unlimited;
        a.poll = auto_mode_i;
        a.irq  = ~auto_mode_i;
      end else begin
        a.stop = 1'b1;
        a.irq  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ret_q    <= '0;
    end else begin
      if (a.stop)      active_q <= 1'b0;
      else if (a.load) active_q <= 1'b1;
      if (a.clr)       ret_q <= '0;
      else if (a.inc)  ret_q <= ret_q + CNT_W'(1);
    end
  end

  assign active_o = active_q;
  assign act_o    = a;
endmodule

// File: rtl/proto_tmo_timer.sv
module proto_tmo_timer
  import tmo_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int CNT_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                auto_mode_i,
  input  logic                src_sel_i,
  input  logic                start_i,
  input  logic                reset_i,
  input  logic                txclk_tick_i,
  input  logic                fsync_tick_i,
  input  logic                ack_i,
  output logic                poll_req_o,
  output logic                irq_o
);
  logic     tmr_active;
  logic     tick;
  logic     expire;
  tmo_act_t act;
  logic     poll_q, irq_q;

  tmo_tick_sel u_sel (
    .src_sel_i    (src_sel_i),
    .active_i     (tmr_active),
    .txclk_tick_i (txclk_tick_i),
    .fsync_tick_i (fsync_tick_i),
    .tick_o       (tick)
  );

  tmo_down_cnt #(.W(PERIOD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (act.load),
    .value_i  (period_i),
    .dec_i    (tick),
    .expire_o (expire)
  );

  tmo_retry_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_i     (count_i),
    .auto_mode_i (auto_mode_i),
    .start_i     (start_i),
    .reset_i     (reset_i),
    .ack_i       (ack_i),
    .expire_i    (expire),
    .active_o    (tmr_active),
    .act_o       (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      poll_q <= act.poll;
      irq_q  <= act.irq;
    end
  end

  assign poll_req_o = poll_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/proto_tmo_timer_chk.sv
module proto_tmo_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic auto_mode_i,
  input logic reset_i,
  input logic ack_i,
  input logic active_i,
  input logic poll_req_o,
  input logic irq_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_i |=> (!irq_o && !poll_req_o)); // R2

  AST_POLL_AUTO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_req_o |-> $past(auto_mode_i)); // R4

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(poll_req_o && irq_o)); // R6

  AST_ACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode_i && ack_i && active_i && !reset_i) |=> (!irq_o && !poll_req_o)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!irq_o && !poll_req_o)); // R11
endmodule

bind proto_tmo_timer proto_tmo_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .auto_mode_i (auto_mode_i),
  .reset_i     (reset_i),
  .ack_i       (ack_i),
  .active_i    (tmr_active),
  .poll_req_o  (poll_req_o),
  .irq_o       (irq_o)
);

// File: tb/tb_proto_tmo_timer.sv
module tb_proto_tmo_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period = '0;
  logic [CW-1:0] count = '0;
  logic          mode = 1'b0, src = 1'b0;
  logic          start = 1'b0, rst_cmd = 1'b0, ttick = 1'b0, ftick = 1'b0, ack = 1'b0;
  logic          poll, irq;

  int checks = 0, fails = 0;
  int n_irq = 0, n_poll = 0;
  bit done = 0;

  // reference state
  bit m_act = 0;
  int m_cnt = 0;
  int m_ret = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  proto_tmo_timer #(.PERIOD_W(PW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .count_i(count),
    .auto_mode_i(mode), .src_sel_i(src), .start_i(start), .reset_i(rst_cmd),
    .txclk_tick_i(ttick), .fsync_tick_i(ftick), .ack_i(ack),
    .poll_req_o(poll), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected outputs for one cycle, from the requirements
  task automatic model(input bit st, rs, tt, ft, ak, output bit e_irq, output bit e_poll);
    bit tk;
    bit lim;
    tk = src ? ft : tt;
    lim = (count == 3'd7);
    e_irq = 0; e_poll = 0;
    if (rs) m_act = 0;
    else if (mode && ak && m_act) begin m_act = 0; m_ret = 0; end
    else if (st) begin m_act = 1; m_cnt = int'(period); m_ret = 0; end
    else if (m_act && tk) begin
      if (m_cnt > 1) m_cnt--;
      else if (lim || m_ret < int'(count)) begin
        if (!lim) m_ret++;
        m_cnt = int'(period);
        if (mode) e_poll = 1; else e_irq = 1;
      end else begin
        m_act = 0; m_cnt = 0; e_irq = 1;
      end
    end
  endtask

  task automatic cyc(input bit st, rs, tt, ft, ak);
    bit ei, ep;
    @(negedge clk);
    start = st; rst_cmd = rs; ttick = tt; ftick = ft; ack = ak;
    model(st, rs, tt, ft, ak, ei, ep);
    @(posedge clk); #1;
    n_irq  += int'(irq);
    n_poll += int'(poll);
    chk(irq === ei, mode ? "R6 irq" : "R8 irq", int'(irq), int'(ei));
    chk(poll === ep, mode ? "R4 poll" : "R8 poll", int'(poll), int'(ep));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, !src, src, 0);
  endtask

  task automatic setup(input bit md, input bit sr, input int p, input int c);
    cyc(0, 1, 0, 0, 0);
    @(negedge clk);
    mode = md; src = sr; period = PW'(p); count = CW'(c);
    cyc(1, 0, 0, 0, 0);
    n_irq = 0; n_poll = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'hC0FFEE);
    repeat (3) @(negedge clk);
    #1;
    chk(irq === 1'b0 && poll === 1'b0, "R1 reset outputs", int'({irq, poll}), 0);
    @(negedge clk); rst_n = 1'b1;
    ticks(4);
    chk(n_irq == 0, "R1 idle after reset", n_irq, 0);

    // CPU mode, single shot
    setup(0, 0, 3, 0);
    ticks(2); chk(n_irq == 0, "R3 before period", n_irq, 0);
    ticks(1); chk(n_irq == 1, "R3 at period", n_irq, 1);
    ticks(6); chk(n_irq == 1, "R11 idle ticks", n_irq, 1);

    // CPU restarts
    setup(0, 0, 2, 2);
    ticks(10); chk(n_irq == 3, "R8 restarts", n_irq, 3);

    // CPU periodic, then reset
    setup(0, 0, 2, 7);
    ticks(10); chk(n_irq == 5, "R9 periodic", n_irq, 5);
    cyc(0, 1, 0, 0, 0);
    ticks(6); chk(n_irq == 5, "R2 reset stops", n_irq, 5);

    // reset beats start
    cyc(0, 1, 0, 0, 0);
    @(negedge clk); period = PW'(1); count = '0;
    cyc(1, 1, 0, 0, 0);
    n_irq = 0; ticks(5); chk(n_irq == 0, "R2 reset over start", n_irq, 0);

    // autonomous, exhaustion
    setup(1, 0, 3, 2);
    ticks(20);
    chk(n_poll == 2, "R4 poll count", n_poll, 2);
    chk(n_irq == 1, "R6 final irq", n_irq, 1);

    // all six retries
    setup(1, 0, 1, 6);
    ticks(12);
    chk(n_poll == 6, "R4 six polls", n_poll, 6);
    chk(n_irq == 1, "R6 final after six", n_irq, 1);

    // autonomous, ack
    setup(1, 0, 2, 3);
    ticks(2); chk(n_poll == 1, "R4 first poll", n_poll, 1);
    cyc(0, 0, 0, 0, 1);
    ticks(10);
    chk(n_poll == 1 && n_irq == 0, "R7 ack stops", n_poll + n_irq, 1);

    // ack beats expiry in the same cycle
    setup(1, 0, 1, 3);
    cyc(0, 0, 1, 0, 1);
    ticks(4);
    chk(n_poll == 0 && n_irq == 0, "R7 ack over expiry", n_poll + n_irq, 0);

    // unlimited polling
    setup(1, 0, 1, 7);
    ticks(12);
    chk(n_poll == 12, "R5 unlimited polls", n_poll, 12);
    chk(n_irq == 0, "R5 no irq", n_irq, 0);

    // ack ignored in CPU mode
    setup(0, 0, 2, 0);
    cyc(0, 0, 0, 0, 1);
    ticks(2); chk(n_irq == 1, "R7 ack ignored cpu", n_irq, 1);

    // source select
    setup(0, 1, 2, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
    chk(n_irq == 0, "R10 txclk ignored", n_irq, 0);
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 1, 0);
    chk(n_irq == 1, "R10 fsync counts", n_irq, 1);

    setup(0, 0, 2, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0);
    chk(n_irq == 0, "R10 fsync ignored", n_irq, 0);

    // period 0
    setup(0, 0, 0, 0);
    ticks(1); chk(n_irq == 1, "R3 period zero", n_irq, 1);

    // maximum period
    setup(0, 0, 255, 0);
    ticks(254); chk(n_irq == 0, "R3 max before", n_irq, 0);
    ticks(1);   chk(n_irq == 1, "R3 max period", n_irq, 1);

    // restart while running
    setup(0, 0, 4, 0);
    ticks(3);
    cyc(1, 0, 0, 0, 0);
    ticks(3); chk(n_irq == 0, "R11 restart reloads", n_irq, 0);
    ticks(1); chk(n_irq == 1, "R11 restart expiry", n_irq, 1);

    // random phase
    for (int seg = 0; seg < 40; seg++) begin
      cyc(0, 1, 0, 0, 0);
      @(negedge clk);
      mode = 1'($urandom); src = 1'($urandom);
      period = PW'($urandom_range(0, 4)); count = CW'($urandom_range(0, 7));
      for (int i = 0; i < 100; i++)
        cyc($urandom_range(0, 99) < 3, $urandom_range(0, 99) < 2,
            $urandom_range(0, 99) < 50, $urandom_range(0, 99) < 30,
            $urandom_range(0, 99) < 5);
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule